// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the trap sequencer of a small 32-bit in-order core. Each cycle it looks at the exception requests raised by the rest of the pipeline (external interrupt, misaligned or protected load or store, bus error on fetch or on data, system call, reserved instruction, signed arithmetic overflow) along with the program counter of the instruction that raised them. When one is taken it records that PC in a dedicated exception-PC register, writes a reason code, enters kernel mode with the exception-level flag set, and steers the fetch unit to one fixed master handler address. The general-purpose link register is never touched, so the interrupted code's return address survives.

The return-from-exception request sends fetch back to the saved exception PC, clears the exception-level flag and restores the privilege mode that was in force before entry. The status, cause and exception-PC registers can be read and written by a move-to/move-from port that only kernel code may use. A user-mode attempt to use that port, or to return from an exception, is turned into a reserved-instruction exception.

The sequencer is a three-state machine. ST_RUN accepts events. The transition TAKE_EXC goes from ST_RUN to ST_ENTER, and TAKE_RET goes from ST_RUN to ST_RETURN. Each of those states lasts exactly one cycle, presents the redirect, ignores all inputs, and leaves through RESUME back to ST_RUN.

Top module: `exc_ctrl`

## Requirements
- R1: After an asynchronous active-low reset, the block is in kernel mode (kernel_mode=1), the status, cause and exception-PC registers read 0, and redir_valid=0.
- R2: An exception taken in ST_RUN gives redir_valid=1 with redir_pc=0x80000180 in the next cycle. When redir_valid=0, redir_pc=0.
- R3: On an exception taken while the exception-level bit is 0, the exception-PC register takes fault_pc, the previous-mode bit takes the current user bit, the user bit clears and the exception-level bit sets. The status register layout is bit0 = exception level, bit1 = user mode (1 = user), bit2 = previous user mode, and all other bits read 0.
- R4: The taken exception's 5-bit code goes to cause bits 6:2, and all other cause bits read 0. The codes are interrupt 0, address error on load/fetch 4, address error on store 5, bus error on fetch 6, bus error on data 7, system call 8, reserved instruction 10, overflow 12.
- R5: When several requests arrive in the same cycle, the highest one wins in this order: fetch bus error, load address error, store address error, data bus error, reserved instruction, overflow, system call, interrupt.
- R6: An interrupt request is ignored while the exception-level bit is 1.
- R7: A kernel-mode return, with no exception in the same cycle, gives redir_valid=1 with redir_pc equal to the exception-PC register in the next cycle. It clears the exception-level bit and copies the previous-mode bit into the user bit.
- R8: An exception taken while the exception-level bit is already 1 updates the cause code and redirects to the handler. The exception-PC register and the previous-mode bit stay unchanged.
- R9: In user mode, csr_rd, csr_wr or eret_req raises a reserved-instruction exception (code 10), and no register write takes place. In user mode csr_rdata reads 0.
- R10: In kernel mode, csr_rdata shows the register picked by csr_sel (0 status, 1 cause, 2 exception PC, 3 reads 0). A csr_wr with no exception or return in the same cycle loads status bits 2:0, cause bits 6:2, or the full exception PC from csr_wdata.
- R11: redir_valid lasts exactly one cycle. Every input presented during a redirect cycle is ignored.
- R12: An exception has precedence over a return and over a register write in the same cycle. Neither of those is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pc | input | 32 | PC of the instruction raising the request |
| req_int | input | 1 | External interrupt request |
| req_adel | input | 1 | Address error on load or fetch |
| req_ades | input | 1 | Address error on store |
| req_ibe | input | 1 | Bus error on instruction fetch |
| req_dbe | input | 1 | Bus error on data access |
| req_sys | input | 1 | System call |
| req_ri | input | 1 | Reserved instruction from decode |
| req_ovf | input | 1 | Signed arithmetic overflow |
| eret_req | input | 1 | Return-from-exception request |
| csr_sel | input | 2 | Register select: 0 status, 1 cause, 2 exception PC |
| csr_rd | input | 1 | Move-from request |
| csr_wr | input | 1 | Move-to request |
| csr_wdata | input | 32 | Move-to data |
| csr_rdata | output | 32 | Move-from data (0 in user mode) |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_pc | output | 32 | Redirect target |
| kernel_mode | output | 1 | 1 when the core runs in kernel mode |

## Verification
A wrong internal state shows up at the ports within a cycle or two. A bad mode bit changes kernel_mode and csr_rdata at once. A wrong saved PC or previous-mode bit stays hidden until the next return, which then redirects to the wrong address or comes back in the wrong mode. A wrong priority or code shows up in the cause read that follows entry. The bench therefore compares the redirect, the mode and the selected register against its model on every clock, and it keeps reading registers through the move-from port so that hidden state becomes visible early.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int CODE_W = 5;
    localparam int NREQ   = 8;

    localparam logic [CODE_W-1:0] EC_INT       = 5'd0;
    localparam logic [CODE_W-1:0] EC_ADDR_LD   = 5'd4;
    localparam logic [CODE_W-1:0] EC_ADDR_ST   = 5'd5;
    localparam logic [CODE_W-1:0] EC_BUS_FETCH = 5'd6;
    localparam logic [CODE_W-1:0] EC_BUS_DATA  = 5'd7;
    localparam logic [CODE_W-1:0] EC_SYSCALL   = 5'd8;
    localparam logic [CODE_W-1:0] EC_RESV      = 5'd10;
    localparam logic [CODE_W-1:0] EC_OVF       = 5'd12;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ENTER  = 2'd1,
        ST_RETURN = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_NONE   = 2'd3
    } csr_sel_e;

    // Code for each slot of the priority vector; slot 0 is the most urgent.
    function automatic logic [CODE_W-1:0] slot_code(input int idx);
        case (idx)
            0:       return EC_BUS_FETCH;
            1:       return EC_ADDR_LD;
            2:       return EC_ADDR_ST;
            3:       return EC_BUS_DATA;
            4:       return EC_RESV;
            5:       return EC_OVF;
            6:       return EC_SYSCALL;
            default: return EC_INT;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
#(
    parameter int N = NREQ
) (
    input  logic [N-1:0]      req,
    output logic              hit,
    output logic [CODE_W-1:0] code
);

    // Scan from least to most urgent so that the lowest index wins.
    always_comb begin
        hit  = 1'b0;
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit  = 1'b1;
                code = slot_code(i);
            end
        end
    end

endmodule

// File: rtl/exc_csr.sv
module exc_csr
    import exc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CODE_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_exc,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic              take_ret,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   rd_data,
    output logic              exl,
    output logic              user,
    output logic [XLEN-1:0]   epc
);

    localparam int STAT_W   = 3;
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    logic              prev_user;
    logic [CODE_W-1:0] code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exl       <= 1'b0;
            user      <= 1'b0;
            prev_user <= 1'b0;
            code      <= '0;
            epc       <= '0;
        end else if (take_exc) begin
            if (!exl) begin
                epc       <= exc_pc;
                prev_user <= user;
            end
            exl  <= 1'b1;
            user <= 1'b0;
            code <= exc_code;
        end else if (take_ret) begin
            exl  <= 1'b0;
            user <= prev_user;
        end else if (wr_en) begin
            unique case (csr_sel_e'(sel))
                SEL_STATUS: begin
                    exl       <= wr_data[0];
                    user      <= wr_data[1];
                    prev_user <= wr_data[2];
                end
                SEL_CAUSE:  code <= wr_data[CODE_MSB:CODE_LSB];
                SEL_EPC:    epc  <= wr_data;
                SEL_NONE:   ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (csr_sel_e'(sel))
            SEL_STATUS: rd_data[STAT_W-1:0]        = {prev_user, user, exl};
            SEL_CAUSE:  rd_data[CODE_MSB:CODE_LSB] = code;
            SEL_EPC:    rd_data                    = epc;
            SEL_NONE:   rd_data                    = '0;
        endcase
    end

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] fault_pc,
    input  logic            req_int,
    input  logic            req_adel,
    input  logic            req_ades,
    input  logic            req_ibe,
    input  logic            req_dbe,
    input  logic            req_sys,
    input  logic            req_ri,
    input  logic            req_ovf,
    input  logic            eret_req,
    input  logic [1:0]      csr_sel,
    input  logic            csr_rd,
    input  logic            csr_wr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic            kernel_mode
);

    seq_state_e        state_q, state_d;
    logic              exl_q, user_q;
    logic [XLEN-1:0]   epc_q, raw_rdata;
    logic [NREQ-1:0]   req_vec;
    logic              hit;
    logic [CODE_W-1:0] hit_code;
    logic              priv_viol, in_run, take_exc, take_ret, do_wr;

    // Kernel-only operations attempted from user mode become reserved-instruction traps.
    assign priv_viol = user_q & (csr_rd | csr_wr | eret_req);
    assign req_vec   = {req_int & ~exl_q, req_sys, req_ovf, req_ri | priv_viol,
                        req_dbe, req_ades, req_adel, req_ibe};

    exc_prio #(.N(NREQ)) u_prio (
        .req  (req_vec),
        .hit  (hit),
        .code (hit_code)
    );

    assign in_run   = (state_q == ST_RUN);
    assign take_exc = in_run & hit;
    assign take_ret = in_run & ~hit & eret_req;
    assign do_wr    = in_run & ~hit & ~eret_req & csr_wr;

    exc_csr #(.XLEN(XLEN)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_exc (take_exc),
        .exc_code (hit_code),
        .exc_pc   (fault_pc),
        .take_ret (take_ret),
        .wr_en    (do_wr),
        .sel      (csr_sel),
        .wr_data  (csr_wdata),
        .rd_data  (raw_rdata),
        .exl      (exl_q),
        .user     (user_q),
        .epc      (epc_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions: TAKE_EXC, TAKE_RET out of ST_RUN; RESUME back from either redirect state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take_exc)      state_d = ST_ENTER;
                else if (take_ret) state_d = ST_RETURN;
            end
            ST_ENTER:  state_d = ST_RUN;
            ST_RETURN: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        redir_valid = 1'b0;
        redir_pc    = '0;
        unique case (state_q)
            ST_RUN: ;
            ST_ENTER: begin
                redir_valid = 1'b1;
                redir_pc    = HANDLER_ADDR;
            end
            ST_RETURN: begin
                redir_valid = 1'b1;
                redir_pc    = epc_q;
            end
            default: ;
        endcase
    end

    assign kernel_mode = ~user_q;
    assign csr_rdata   = user_q ? '0 : raw_rdata;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] fault_pc,
    input logic            req_int,
    input logic            req_adel,
    input logic            req_ades,
    input logic            req_ibe,
    input logic            req_dbe,
    input logic            req_sys,
    input logic            req_ri,
    input logic            req_ovf,
    input logic            eret_req,
    input logic            csr_rd,
    input logic            csr_wr,
    input logic            redir_valid,
    input logic [XLEN-1:0] redir_pc,
    input logic            kernel_mode,
    input logic            exl_q,
    input logic [XLEN-1:0] epc_q
);

    logic sync_req;
    assign sync_req = req_ibe | req_adel | req_ades | req_dbe | req_ri | req_ovf | req_sys;

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    assert_handler_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && sync_req) |=> (redir_valid && redir_pc == HANDLER_ADDR));

    assert_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && !exl_q && sync_req) |=> (exl_q && kernel_mode && epc_q == $past(fault_pc)));

    assert_keep_epc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && exl_q && sync_req) |=> (epc_q == $past(epc_q)));

    assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && exl_q && !sync_req && !eret_req && !csr_rd && !csr_wr) |=> !redir_valid);

    assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!redir_valid && kernel_mode && eret_req && !sync_req && !(req_int && !exl_q))
        |=> (redir_valid && redir_pc == $past(epc_q) && !exl_q));

endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .HANDLER_ADDR(HANDLER_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_pc    (fault_pc),
    .req_int     (req_int),
    .req_adel    (req_adel),
    .req_ades    (req_ades),
    .req_ibe     (req_ibe),
    .req_dbe     (req_dbe),
    .req_sys     (req_sys),
    .req_ri      (req_ri),
    .req_ovf     (req_ovf),
    .eret_req    (eret_req),
    .csr_rd      (csr_rd),
    .csr_wr      (csr_wr),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .kernel_mode (kernel_mode),
    .exl_q       (exl_q),
    .epc_q       (epc_q)
);

// File: tb/sim_exc_ctrl.sv
module sim_exc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fault_pc = '0;
    logic        req_int = 0, req_adel = 0, req_ades = 0, req_ibe = 0;
    logic        req_dbe = 0, req_sys = 0, req_ri = 0, req_ovf = 0;
    logic        eret_req = 0, csr_rd = 0, csr_wr = 0;
    logic [1:0]  csr_sel = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata, redir_pc;
    logic        redir_valid, kernel_mode;

    always #10 clk = ~clk;

    exc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .fault_pc(fault_pc),
        .req_int(req_int), .req_adel(req_adel), .req_ades(req_ades), .req_ibe(req_ibe),
        .req_dbe(req_dbe), .req_sys(req_sys), .req_ri(req_ri), .req_ovf(req_ovf),
        .eret_req(eret_req), .csr_sel(csr_sel), .csr_rd(csr_rd), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .kernel_mode(kernel_mode)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string tag = "R1";

    // Behavioural reference state
    bit          m_exl, m_user, m_prev, m_busy;
    logic [31:0] m_epc, m_rpc;
    int          m_code;

    function automatic logic [31:0] m_read();
        if (m_user) return 32'h0;
        case (csr_sel)
            2'd0:    return {29'h0, m_prev, m_user, m_exl};
            2'd1:    return 32'(m_code) << 2;
            2'd2:    return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_exl = 0; m_user = 0; m_prev = 0; m_busy = 0;
            m_epc = '0; m_rpc = '0; m_code = 0;
        end else if (m_busy) begin
            m_busy = 0;
        end else begin
            int c;
            bit ri;
            ri = req_ri || (m_user && (csr_rd || csr_wr || eret_req));
            c = -1;
            if (req_ibe)                 c = 6;
            else if (req_adel)           c = 4;
            else if (req_ades)           c = 5;
            else if (req_dbe)            c = 7;
            else if (ri)                 c = 10;
            else if (req_ovf)            c = 12;
            else if (req_sys)            c = 8;
            else if (req_int && !m_exl)  c = 0;
            if (c >= 0) begin
                if (!m_exl) begin m_epc = fault_pc; m_prev = m_user; end
                m_user = 0; m_exl = 1; m_code = c;
                m_busy = 1; m_rpc = 32'h8000_0180;
            end else if (eret_req) begin
                m_user = m_prev; m_exl = 0;
                m_busy = 1; m_rpc = m_epc;
            end else if (csr_wr) begin
                case (csr_sel)
                    2'd0: begin m_exl = csr_wdata[0]; m_user = csr_wdata[1]; m_prev = csr_wdata[2]; end
                    2'd1: m_code = int'(csr_wdata[6:2]);
                    2'd2: m_epc = csr_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("redir_valid", 32'(redir_valid), 32'(m_busy));
        chk("redir_pc", redir_pc, m_busy ? m_rpc : 32'h0);
        chk("kernel_mode", 32'(kernel_mode), 32'(!m_user));
        chk("csr_rdata", csr_rdata, m_read());
    endtask

    task automatic idle();
        {req_int, req_adel, req_ades, req_ibe, req_dbe, req_sys, req_ri, req_ovf} = '0;
        eret_req = 0; csr_rd = 0; csr_wr = 0; csr_wdata = '0;
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    task automatic rd(input logic [1:0] s);
        idle(); csr_sel = s; tick();
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        idle(); csr_sel = s; csr_wr = 1; csr_wdata = d; tick(); idle();
    endtask

    task automatic ret();
        idle(); eret_req = 1; tick(); idle(); tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL %s watchdog actual=hung expected=finished", tag);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        @(negedge clk); @(negedge clk);
        tag = "R1"; compare();
        rst_n = 1;
        for (int s = 0; s < 4; s++) rd(2'(s));

        // Syscall from kernel: redirect, save PC, code 8
        tag = "R2"; idle(); fault_pc = 32'h0000_0400; req_sys = 1; csr_sel = 2'd1; tick();
        idle(); tag = "R4"; tick();
        tag = "R3"; rd(2'd2); rd(2'd0);
        tag = "R7"; ret(); rd(2'd0);

        // Enter user mode, then overflow from user
        tag = "R10"; wr(2'd0, 32'h2); wr(2'd0, 32'h0); wr(2'd2, 32'h1234_5678); rd(2'd2);
        wr(2'd1, 32'h0000_0028); rd(2'd1); wr(2'd0, 32'h2);
        tag = "R3"; idle(); fault_pc = 32'h0000_1000; req_ovf = 1; tick(); idle(); tick();
        rd(2'd0); rd(2'd2);
        tag = "R8"; fault_pc = 32'h0000_2000; req_adel = 1; tick(); idle(); tick(); rd(2'd2); rd(2'd1);
        tag = "R6"; req_int = 1; csr_sel = 2'd1; tick(3); idle();
        tag = "R7"; ret(); rd(2'd0);

        // User-mode privileged attempts become reserved instruction
        tag = "R9"; idle(); csr_sel = 2'd0; csr_wr = 1; csr_wdata = 32'h0; fault_pc = 32'h3000; tick(); idle(); tick();
        wr(2'd0, 32'h2); rd(2'd1);
        idle(); csr_rd = 1; fault_pc = 32'h3100; tick(); idle(); tick(); rd(2'd1); wr(2'd0, 32'h2);
        idle(); eret_req = 1; fault_pc = 32'h3200; tick(); idle(); tick(); rd(2'd2); rd(2'd1);
        wr(2'd0, 32'h0);

        // Priority among simultaneous requests
        tag = "R5";
        for (int p = 0; p < 8; p++) begin
            idle(); csr_sel = 2'd1; fault_pc = 32'h5000 + 32'(p * 4);
            req_int = 1; req_sys = (p < 7); req_ovf = (p < 6); req_ri = (p < 5);
            req_dbe = (p < 4); req_ades = (p < 3); req_adel = (p < 2); req_ibe = (p < 1);
            tick(); idle(); tick(); rd(2'd1);
            ret();
        end

        // Interrupt unmasked after return
        tag = "R4"; idle(); req_int = 1; fault_pc = 32'h6000; tick(); idle(); tick(); rd(2'd1);
        tag = "R11"; idle(); req_sys = 1; eret_req = 1; tick(); tick(); idle(); tick(); rd(2'd0);
        tag = "R12"; wr(2'd0, 32'h0); idle(); req_ovf = 1; eret_req = 1; csr_wr = 1; csr_sel = 2'd2;
        csr_wdata = 32'hDEAD_0000; fault_pc = 32'h7000; tick(); idle(); tick(); rd(2'd2); rd(2'd0);
        wr(2'd0, 32'h0);

        // Mixed random traffic
        tag = "R5";
        for (int i = 0; i < 600; i++) begin
            idle();
            fault_pc = $urandom & 32'hFFFF_FFFC;
            csr_sel  = 2'($urandom);
            req_int  = ($urandom % 8) == 0;  req_sys  = ($urandom % 12) == 0;
            req_ovf  = ($urandom % 12) == 0; req_ri   = ($urandom % 16) == 0;
            req_dbe  = ($urandom % 20) == 0; req_ades = ($urandom % 20) == 0;
            req_adel = ($urandom % 20) == 0; req_ibe  = ($urandom % 24) == 0;
            eret_req = ($urandom % 6) == 0;  csr_rd   = ($urandom % 5) == 0;
            csr_wr   = ($urandom % 5) == 0;  csr_wdata = $urandom;
            tick();
        end
        idle(); tick(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule